// File: doc/BRIEF.md
# Prefetch Request Queue with Remote-Source Hinting

This block holds cache-line prefetch requests for a group of pixel processors that run in decoupled access/execute style. Address logic upstream works out, from per-pixel data, which lines each pixel will need. It pushes one request per line into this queue, tagged with the L1 cache (a pixel or texture cache on one of the cores) that should receive it. The queue then hands the requests to their target caches in arrival order.

On every insertion the new line address is compared in the same cycle against every valid entry already held, including one that is leaving in that cycle. If a held entry names the same line for a different L1 cache, that cache is likely to own the line soon. Its identifier is stored with the new request as a source hint. Without such a match the hint names L2. On a miss, the receiving cache controller sends its fill request to the hinted location, so lines shared between cores are served from a neighbour's small L1 rather than from L2.

Cache identifiers are CID_W-bit integers. The all-ones code is reserved for L2.

Top module: `pfq_source_queue`

## Requirements
- R1: After reset the queue is empty: `deq_valid` is 0 and `enq_ready` is 1.
- R2: Requests leave in acceptance order with address and target unchanged. A request accepted into an empty queue appears on the dispatch side in the next cycle.
- R3: The queue holds DEPTH entries (default 16). With DEPTH entries held and `deq_ready` low, `enq_ready` is 0 and nothing is accepted.
- R4: With DEPTH entries held and `deq_ready` high, `enq_ready` is 1. A request offered in that cycle is accepted while the head leaves, and the queue stays full.
- R5: A request whose address matches no held entry is stored with source = L2 code, the all-ones value of CID_W bits (7 by default).
- R6: A request whose address matches a held entry that has a different target is stored with source = that entry's target.
- R7: When several held entries qualify under R6, the most recently accepted of them supplies the source.
- R8: A held entry whose target equals the new request's target is ignored by the compare. A dispatched request's source therefore never equals its own target.
- R9: An entry that leaves the queue in the same cycle as an insertion still takes part in that insertion's compare.
- R10: While `deq_valid` is 1 and `deq_ready` is 0, the dispatch outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | A new prefetch request is offered |
| enq_ready | output | 1 | The queue accepts the offered request this cycle |
| enq_addr | input | ADDR_W | Cache-line address of the offered request |
| enq_target | input | CID_W | L1 cache that should receive the request |
| deq_valid | output | 1 | The oldest request is presented |
| deq_ready | input | 1 | The target cache takes the presented request |
| deq_addr | output | ADDR_W | Line address of the presented request |
| deq_target | output | CID_W | Target L1 cache of the presented request |
| deq_source | output | CID_W | Hinted location for the line on a miss (L1 id, or all-ones for L2) |

## Verification
The source hint is computed and registered together with the entry in the cycle of acceptance. It is first visible one cycle later, and only when that entry reaches the head. The bench therefore works out each expected hint from its own list of held requests at the sampling point before the accepting edge, including an entry that is departing at that edge. It compares the hint when the entry is dispatched. The `enq_ready` and `deq_valid` responses to fullness, emptiness and `deq_ready` are combinational on the registered count. They are sampled at the falling edge of the cycle in which they matter. Stalled outputs are compared across several stalled cycles.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // next position in a ring of 'depth' slots
  function automatic int ring_next(int p, int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // slot holding the k-th oldest entry when the oldest sits at 'head'
  function automatic int slot_at(int head, int k, int depth);
    return (head + k) % depth;
  endfunction

endpackage

// File: rtl/pfq_ring.sv
module pfq_ring #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 26,
  parameter int CID_W  = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic                    pop,
  input  logic [ADDR_W-1:0]       push_addr,
  input  logic [CID_W-1:0]        push_tgt,
  input  logic [CID_W-1:0]        push_src,
  output logic [ADDR_W-1:0]       head_addr,
  output logic [CID_W-1:0]        head_tgt,
  output logic [CID_W-1:0]        head_src,
  output logic [PTR_W-1:0]        head_ptr,
  output logic [CNT_W-1:0]        fill,
  output logic [DEPTH-1:0]        slot_vld,
  output logic [DEPTH*ADDR_W-1:0] slot_addr,
  output logic [DEPTH*CID_W-1:0]  slot_tgt
);
  logic [ADDR_W-1:0] addr_m [DEPTH];
  logic [CID_W-1:0]  tgt_m  [DEPTH];
  logic [CID_W-1:0]  src_m  [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      wr_ptr   <= '0;
      fill     <= '0;
      slot_vld <= '0;
    end else begin
      if (pop) begin
        slot_vld[head_ptr] <= 1'b0;
        head_ptr <= PTR_W'(pfq_pkg::ring_next(int'(head_ptr), DEPTH));
      end
      if (push) begin
        slot_vld[wr_ptr] <= 1'b1;
        wr_ptr <= PTR_W'(pfq_pkg::ring_next(int'(wr_ptr), DEPTH));
      end
      fill <= fill + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_m[wr_ptr] <= push_addr;
      tgt_m[wr_ptr]  <= push_tgt;
      src_m[wr_ptr]  <= push_src;
    end
  end

  assign head_addr = addr_m[head_ptr];
  assign head_tgt  = tgt_m[head_ptr];
  assign head_src  = src_m[head_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_flat
    assign slot_addr[i*ADDR_W +: ADDR_W] = addr_m[i];
    assign slot_tgt[i*CID_W +: CID_W]    = tgt_m[i];
  end
endmodule

// File: rtl/pfq_source_pick.sv
module pfq_source_pick #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 26,
  parameter int CID_W  = 3,
  parameter logic [CID_W-1:0] L2_ID = '1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]        slot_vld,
  input  logic [DEPTH*ADDR_W-1:0] slot_addr,
  input  logic [DEPTH*CID_W-1:0]  slot_tgt,
  input  logic [PTR_W-1:0]        head_ptr,
  input  logic [ADDR_W-1:0]       new_addr,
  input  logic [CID_W-1:0]        new_tgt,
  output logic [DEPTH-1:0]        slot_hit,
  output logic                    any_hit,
  output logic [CID_W-1:0]        src_id
);
  // per-slot qualified match: valid, same line, different cache
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign slot_hit[i] = slot_vld[i]
                      && (slot_addr[i*ADDR_W +: ADDR_W] == new_addr)
                      && (slot_tgt[i*CID_W +: CID_W] != new_tgt);
  end

  assign any_hit = |slot_hit;

  // walk oldest to youngest; the last qualifying slot wins
  always_comb begin
    src_id = L2_ID;
    for (int k = 0; k < DEPTH; k++) begin
      int s;
      s = pfq_pkg::slot_at(int'(head_ptr), k, DEPTH);
      if (slot_hit[s]) src_id = slot_tgt[s*CID_W +: CID_W];
    end
  end
endmodule

// File: rtl/pfq_source_queue.sv
module pfq_source_queue #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 26,
  parameter int CID_W  = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam logic [CID_W-1:0] L2_ID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [CID_W-1:0]  enq_target,
  output logic              deq_valid,
  input  logic              deq_ready,
  output logic [ADDR_W-1:0] deq_addr,
  output logic [CID_W-1:0]  deq_target,
  output logic [CID_W-1:0]  deq_source
);
  logic                    enq_fire;
  logic                    deq_fire;
  logic                    q_full;
  logic                    q_empty;
  logic                    match_any;
  logic [DEPTH-1:0]        match_vec;
  logic [CID_W-1:0]        hint_id;
  logic [PTR_W-1:0]        head_ptr;
  logic [CNT_W-1:0]        fill;
  logic [DEPTH-1:0]        slot_vld;
  logic [DEPTH*ADDR_W-1:0] slot_addr;
  logic [DEPTH*CID_W-1:0]  slot_tgt;

  assign q_full    = (fill == CNT_W'(DEPTH));
  assign q_empty   = (fill == '0);
  assign deq_valid = !q_empty;
  assign deq_fire  = deq_valid && deq_ready;
  assign enq_ready = !q_full || deq_ready;
  assign enq_fire  = enq_valid && enq_ready;

  pfq_source_pick #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CID_W(CID_W), .L2_ID(L2_ID)
  ) u_pick (
    .slot_vld (slot_vld),
    .slot_addr(slot_addr),
    .slot_tgt (slot_tgt),
    .head_ptr (head_ptr),
    .new_addr (enq_addr),
    .new_tgt  (enq_target),
    .slot_hit (match_vec),
    .any_hit  (match_any),
    .src_id   (hint_id)
  );

  pfq_ring #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CID_W(CID_W)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (enq_fire),
    .pop      (deq_fire),
    .push_addr(enq_addr),
    .push_tgt (enq_target),
    .push_src (hint_id),
    .head_addr(deq_addr),
    .head_tgt (deq_target),
    .head_src (deq_source),
    .head_ptr (head_ptr),
    .fill     (fill),
    .slot_vld (slot_vld),
    .slot_addr(slot_addr),
    .slot_tgt (slot_tgt)
  );
endmodule

// File: rtl/pfq_source_queue_chk.sv
module pfq_source_queue_chk #(
  parameter int ADDR_W = 26,
  parameter int CID_W  = 3,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enq_fire,
  input logic              enq_ready,
  input logic              deq_valid,
  input logic              deq_ready,
  input logic              q_full,
  input logic              match_any,
  input logic [ADDR_W-1:0] enq_addr,
  input logic [ADDR_W-1:0] deq_addr,
  input logic [CID_W-1:0]  deq_target,
  input logic [CID_W-1:0]  deq_source
);
  assert_first_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire && !deq_valid |=> deq_valid && deq_addr == $past(enq_addr));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_full && !deq_ready |-> !enq_ready);

  assert_full_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    q_full && enq_fire && deq_valid && deq_ready |=> q_full);

  assert_hint_not_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> deq_source != deq_target);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid && !deq_ready |=> deq_valid && $stable(deq_addr)
      && $stable(deq_target) && $stable(deq_source));

  // R6: a qualified match on an empty queue is impossible
  assert_hit_needs_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_any |-> deq_valid);
endmodule

bind pfq_source_queue pfq_source_queue_chk #(
  .ADDR_W(ADDR_W), .CID_W(CID_W), .DEPTH(DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enq_fire  (enq_fire),
  .enq_ready (enq_ready),
  .deq_valid (deq_valid),
  .deq_ready (deq_ready),
  .q_full    (q_full),
  .match_any (match_any),
  .enq_addr  (enq_addr),
  .deq_addr  (deq_addr),
  .deq_target(deq_target),
  .deq_source(deq_source)
);

// File: tb/tb_pfq_source_queue.sv
module tb_pfq_source_queue;
  localparam int DEPTH = 16;
  localparam int AW = 26;
  localparam int CW = 3;
  localparam logic [CW-1:0] L2C = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0, enq_ready;
  logic [AW-1:0] enq_addr = '0;
  logic [CW-1:0] enq_target = '0;
  logic deq_valid, deq_ready = 1'b0;
  logic [AW-1:0] deq_addr;
  logic [CW-1:0] deq_target, deq_source;

  always #5 clk = ~clk;

  pfq_source_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .CID_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_addr(enq_addr), .enq_target(enq_target),
    .deq_valid(deq_valid), .deq_ready(deq_ready),
    .deq_addr(deq_addr), .deq_target(deq_target), .deq_source(deq_source)
  );

  typedef struct { logic [AW-1:0] a; logic [CW-1:0] t; logic [CW-1:0] s; } item_t;
  item_t sb[$];
  int tests = 0, fails = 0, cycles = 0;
  string tag = "R5";
  logic done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard at the falling edge (inputs are stable then)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      item_t n;
      bit take;
      take = enq_valid && enq_ready;
      if (take) begin
        n.a = enq_addr; n.t = enq_target; n.s = L2C;
        foreach (sb[i])   // oldest first, youngest qualifying wins
          if (sb[i].a == enq_addr && sb[i].t != enq_target) n.s = sb[i].t;
      end
      if (deq_valid && deq_ready) begin
        if (sb.size() == 0) check(0, "R2", "dispatch from empty model", 1, 0);
        else begin
          item_t e;
          e = sb.pop_front();
          check(deq_addr == e.a && deq_target == e.t, "R2", "addr/target",
                {deq_addr, deq_target}, {e.a, e.t});
          check(deq_source == e.s, tag, "source hint", deq_source, e.s);
        end
      end
      if (take) sb.push_back(n);
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [CW-1:0] t);
    bit acc;
    enq_valid = 1'b1; enq_addr = a; enq_target = t;
    do begin
      @(negedge clk); acc = enq_ready;
      @(posedge clk); #1;
    end while (!acc);
    enq_valid = 1'b0;
  endtask

  task automatic drain();
    deq_ready = 1'b1;
    repeat (DEPTH + 4) begin @(posedge clk); #1; end
    deq_ready = 1'b0;
    @(negedge clk);
    check(!deq_valid && sb.size() == 0, "R2", "drained", deq_valid, 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!deq_valid, "R1", "deq_valid after reset", deq_valid, 0);
    check(enq_ready, "R1", "enq_ready after reset", enq_ready, 1);
    @(posedge clk); #1;

    // R2: latency from empty
    push(26'h40, 3'd2);
    @(negedge clk);
    check(deq_valid && deq_addr == 26'h40 && deq_target == 3'd2, "R2",
          "next-cycle visibility", deq_addr, 26'h40);
    @(posedge clk); #1;
    drain();

    // R5: distinct addresses
    tag = "R5";
    push(26'h100, 3'd0); push(26'h101, 3'd1); push(26'h102, 3'd2);
    @(negedge clk);
    check(deq_source == L2C, "R5", "head hint L2", deq_source, L2C);
    @(posedge clk); #1;
    drain();

    // R6: single remote match
    tag = "R6";
    push(26'h200, 3'd1); push(26'h200, 3'd2);
    drain();

    // R7: youngest wins (expect 2 for the third)
    tag = "R7";
    push(26'h300, 3'd1); push(26'h300, 3'd2); push(26'h300, 3'd3);
    deq_ready = 1'b1;
    repeat (2) begin @(posedge clk); #1; end
    deq_ready = 1'b0;
    @(negedge clk);
    check(deq_source == 3'd2, "R7", "youngest match", deq_source, 3'd2);
    @(posedge clk); #1;
    drain();

    // R8: same-target entries ignored
    tag = "R8";
    push(26'h400, 3'd1); push(26'h400, 3'd2); push(26'h400, 3'd2);
    push(26'h410, 3'd4); push(26'h410, 3'd4);
    drain();

    // R9: departing entry still compared
    tag = "R9";
    push(26'h500, 3'd5);
    enq_valid = 1'b1; enq_addr = 26'h500; enq_target = 3'd3; deq_ready = 1'b1;
    @(posedge clk); #1;
    enq_valid = 1'b0; deq_ready = 1'b0;
    @(negedge clk);
    check(deq_valid && deq_source == 3'd5, "R9", "hint from leaving entry",
          deq_source, 3'd5);
    @(posedge clk); #1;
    drain();

    // R3 / R4 / R10: fill up
    tag = "R3";
    for (int i = 0; i < DEPTH; i++) push(AW'(26'h600 + i % 4), CW'(i % 7));
    enq_valid = 1'b1; enq_addr = 26'h601; enq_target = 3'd6;
    @(negedge clk);
    check(!enq_ready, "R3", "enq_ready when full", enq_ready, 0);
    begin
      logic [AW-1:0] a0; logic [CW-1:0] t0, s0;
      a0 = deq_addr; t0 = deq_target; s0 = deq_source;
      repeat (3) begin @(posedge clk); #1; end
      @(negedge clk);
      check(deq_addr == a0 && deq_target == t0 && deq_source == s0, "R10",
            "stalled outputs", deq_addr, a0);
    end
    @(posedge clk); #1;
    tag = "R4";
    deq_ready = 1'b1;
    @(negedge clk);
    check(enq_ready, "R4", "enq_ready full with dispatch", enq_ready, 1);
    @(posedge clk); #1;
    enq_valid = 1'b0; deq_ready = 1'b0;
    @(negedge clk);
    check(!enq_ready, "R4", "still full after swap", enq_ready, 0);
    @(posedge clk); #1;
    drain();

    // mixed traffic with shared lines
    tag = "R7";
    fork
      for (int i = 0; i < 300; i++)
        push(AW'(26'h700 + $urandom_range(0, 3)), CW'($urandom_range(0, 6)));
      repeat (700) begin
        deq_ready = ($urandom_range(0, 2) != 0);
        @(posedge clk); #1;
      end
    join
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule